// File: doc/BRIEF.md
# Latched Status Event Register Group

This block gathers two status reporting groups of an instrument controller behind one small register port. Each group takes a 16-bit live condition vector, holds a sticky event register whose latchable bits are captured while their condition is high and cleared when the host reads the event register, and keeps a writable enable mask. Each group produces one summary bit: the OR of the event bits that the mask enables. The questionable group's summary feeds bit 3 of a status byte. The operation group drives a second summary bit.

The host addresses the registers with a 3-bit address: bit 2 selects the group (0 = questionable, 1 = operation) and bits 1:0 select the register (0 = condition, 1 = event, 2 = enable, 3 = nothing, reads zero). A read strobe registers the selected value onto the read data port one clock later. A write strobe only affects the enable registers. A preset strobe loads the default enable masks into both groups.

In the questionable group, only bits 14, 13, 12, 6, 3, 1 and 0 exist: sinking energy from the load, current error, voltage error, slave error, thermal error, current-mode and voltage-mode. Of these, only current error (13) and voltage error (12) can latch. The operation group uses and latches all 16 bits.

Top module: `status_group_top`

## Requirements
- R1: After reset, both event registers and both enable registers read 0, the read data is 0, and both summary outputs are low.
- R2: A condition read returns the live condition input ANDed with the group's used-bit mask (questionable mask 0x704B, operation mask 0xFFFF), one clock after the read strobe.
- R3: In the questionable group only bits 13 and 12 ever latch into the event register. A high level on any other condition bit, bits 1 and 0 included, leaves the event register at 0.
- R4: An event bit is set on any clock edge at which its latchable condition bit is 1, and it stays set after the condition drops until the event register is read.
- R5: A read of a group's event register returns its value one clock after the strobe and clears it. Reads of that group's condition or enable register do not clear it.
- R6: If a latchable condition is high at the same edge as an event read-clear, the read returns the old value and the new event bit stays set afterwards.
- R7: A write to an enable register stores the write data ANDed with the group's used-bit mask. Writes to condition or event addresses change nothing.
- R8: Each summary output is high exactly when its group's event register and enable register share a set bit. It follows a change to either register in the cycle after the edge that made the change.
- R9: A preset strobe loads 255 masked by the used bits (0x004B) into the questionable enable register and 8193 (0x2001) into the operation enable register. Preset takes priority over a write in the same cycle.
- R10: The operation group latches every condition bit into its event register.
- R11: Accesses to one group never change the event or enable register of the other group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ques_cond_i | input | 16 | Live questionable conditions |
| oper_cond_i | input | 16 | Live operation conditions |
| addr_i | input | 3 | Bit 2 selects the group, bits 1:0 select the register |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| preset_i | input | 1 | Load default enable masks |
| rdata_o | output | 16 | Registered read data |
| ques_sum_o | output | 1 | Questionable summary (status byte bit 3) |
| oper_sum_o | output | 1 | Operation summary |

## Verification
The bench holds every questionable condition bit high and expects only 0x3000 in the event register. A design that latched the mode bits or the unused positions would return extra bits. It pulses a condition for a single cycle and reads later, which catches a register that only tracks the live input. It raises a new event in the same cycle as a read-clear: a design that lets the clear win would lose the bit, and one that merges the new bit into the read data would return the wrong value. It also checks the masked preset values and the isolation between groups, which exposes a swapped default or a decode that ignores the group bit.

// File: rtl/stat_grp_pkg.sv
package stat_grp_pkg;

    localparam int DW      = 16;
    localparam int NUM_GRP = 2;
    localparam int AW      = 3;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [1:0] {
        REG_COND   = 2'd0,
        REG_EVENT  = 2'd1,
        REG_ENABLE = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     grp;
        reg_sel_e sel;
    } addr_t;

    typedef struct packed {
        word_t used;
        word_t latch;
        word_t preset;
    } grp_cfg_t;

    // group 0: questionable, group 1: operation
    function automatic grp_cfg_t grp_cfg(input int g);
        grp_cfg_t c;
        if (g == 0) begin
            c.used   = 16'h704B;
            c.latch  = 16'h3000;
            c.preset = 16'd255;
        end else begin
            c.used   = 16'hFFFF;
            c.latch  = 16'hFFFF;
            c.preset = 16'd8193;
        end
        return c;
    endfunction

    function automatic word_t next_event(input word_t evt, input word_t cond,
                                         input word_t latch, input logic clr);
        word_t base;
        base = clr ? '0 : evt;
        return base | (cond & latch);
    endfunction

endpackage

// File: rtl/stat_event_latch.sv
module stat_event_latch
    import stat_grp_pkg::*;
#(
    parameter int            W     = DW,
    parameter logic [W-1:0]  LATCH = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cond,
    input  logic         clr,
    output logic [W-1:0] evt_q
);
    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= next_event(evt_q, cond, LATCH, clr);
    end
endmodule

// File: rtl/stat_enable_reg.sv
module stat_enable_reg #(
    parameter int            W      = 16,
    parameter logic [W-1:0]  USED   = '1,
    parameter logic [W-1:0]  PRESET = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         preset,
    output logic [W-1:0] enb_q
);
    localparam logic [W-1:0] PRESET_M = PRESET & USED;

    always_ff @(posedge clk) begin
        if (rst)         enb_q <= '0;
        else if (preset) enb_q <= PRESET_M;
        else if (wr)     enb_q <= wdata & USED;
    end
endmodule

// File: rtl/stat_group.sv
module stat_group
    import stat_grp_pkg::*;
#(
    parameter int            W      = DW,
    parameter logic [W-1:0]  USED   = '1,
    parameter logic [W-1:0]  LATCH  = '1,
    parameter logic [W-1:0]  PRESET = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cond,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         preset,
    output logic [W-1:0] cond_view,
    output logic [W-1:0] evt_q,
    output logic [W-1:0] enb_q,
    output logic         sum
);
    localparam logic [W-1:0] LATCH_M = LATCH & USED;

    stat_event_latch #(.W(W), .LATCH(LATCH_M)) u_evt (
        .clk(clk), .rst(rst), .cond(cond), .clr(clr), .evt_q(evt_q)
    );

    stat_enable_reg #(.W(W), .USED(USED), .PRESET(PRESET)) u_enb (
        .clk(clk), .rst(rst), .wr(wr), .wdata(wdata),
        .preset(preset), .enb_q(enb_q)
    );

    assign cond_view = cond & USED;
    assign sum       = |(evt_q & enb_q);
endmodule

// File: rtl/status_group_top.sv
module status_group_top
    import stat_grp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ques_cond_i,
    input  logic [DW-1:0] oper_cond_i,
    input  logic [AW-1:0] addr_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          preset_i,
    output logic [DW-1:0] rdata_o,
    output logic          ques_sum_o,
    output logic          oper_sum_o
);
    addr_t a;
    assign a = addr_t'(addr_i);

    word_t cond_in  [NUM_GRP];
    word_t cond_v   [NUM_GRP];
    word_t evt_v    [NUM_GRP];
    word_t enb_v    [NUM_GRP];
    logic  sum_v    [NUM_GRP];

    assign cond_in[0] = ques_cond_i;
    assign cond_in[1] = oper_cond_i;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam grp_cfg_t CFG = grp_cfg(g);
        logic hit;
        assign hit = (int'(a.grp) == g);

        stat_group #(
            .W(DW), .USED(CFG.used), .LATCH(CFG.latch), .PRESET(CFG.preset)
        ) u_grp (
            .clk      (clk),
            .rst      (rst),
            .cond     (cond_in[g]),
            .clr      (rd_i && hit && a.sel == REG_EVENT),
            .wr       (wr_i && hit && a.sel == REG_ENABLE),
            .wdata    (wdata_i),
            .preset   (preset_i),
            .cond_view(cond_v[g]),
            .evt_q    (evt_v[g]),
            .enb_q    (enb_v[g]),
            .sum      (sum_v[g])
        );
    end

    word_t rd_mux;
    always_comb begin
        unique case (a.sel)
            REG_COND:   rd_mux = cond_v[a.grp];
            REG_EVENT:  rd_mux = evt_v[a.grp];
            REG_ENABLE: rd_mux = enb_v[a.grp];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_o <= '0;
        else if (rd_i) rdata_o <= rd_mux;
    end

    assign ques_sum_o = sum_v[0];
    assign oper_sum_o = sum_v[1];
endmodule

// File: rtl/status_group_chk.sv
module status_group_chk
    import stat_grp_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr_i,
    input logic          rd_i,
    input logic          preset_i,
    input logic [DW-1:0] ques_cond_i,
    input logic          ques_sum_o,
    input logic          oper_sum_o,
    input logic [DW-1:0] evt0,
    input logic [DW-1:0] enb0,
    input logic [DW-1:0] enb1
);
    logic clr0;
    assign clr0 = rd_i && addr_i == 3'b001;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!ques_sum_o && !oper_sum_o)); // R1

    AST_QUES_LATCH_ONLY: assert property (@(posedge clk) disable iff (rst)
        (evt0 & ~16'h3000) == 16'h0); // R3

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr0 |=> ((evt0 & $past(evt0)) == $past(evt0))); // R4

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (clr0 && (ques_cond_i & 16'h3000) == 16'h0) |=> evt0 == 16'h0); // R5

    AST_ENB_MASKED: assert property (@(posedge clk) disable iff (rst)
        (enb0 & ~16'h704B) == 16'h0); // R7

    AST_SUM_NEEDS_ENB: assert property (@(posedge clk) disable iff (rst)
        ques_sum_o |-> enb0 != 16'h0); // R8

    AST_PRESET_VALS: assert property (@(posedge clk) disable iff (rst)
        preset_i |=> (enb0 == 16'h004B && enb1 == 16'h2001)); // R9
endmodule

bind status_group_top status_group_chk u_chk (
    .clk(clk), .rst(rst), .addr_i(addr_i), .rd_i(rd_i), .preset_i(preset_i),
    .ques_cond_i(ques_cond_i), .ques_sum_o(ques_sum_o), .oper_sum_o(oper_sum_o),
    .evt0(evt_v[0]), .enb0(enb_v[0]), .enb1(enb_v[1])
);

// File: tb/sim_status_group_top.sv
module sim_status_group_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst;
    logic [15:0] ques_cond, oper_cond, wdata, rdata;
    logic [2:0]  addr;
    logic        rd, wr, preset, qsum, osum;
    int n_chk = 0, n_bad = 0;

    localparam logic [2:0] Q_COND = 3'd0, Q_EVT = 3'd1, Q_ENB = 3'd2;
    localparam logic [2:0] O_COND = 3'd4, O_EVT = 3'd5, O_ENB = 3'd6;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_group_top u0 (
        .clk(clk), .rst(rst), .ques_cond_i(ques_cond), .oper_cond_i(oper_cond),
        .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .preset_i(preset),
        .rdata_o(rdata), .ques_sum_o(qsum), .oper_sum_o(osum)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [2:0] ad, output logic [15:0] v);
        @(negedge clk); addr = ad; rd = 1;
        @(negedge clk); rd = 0; v = rdata;
    endtask

    task automatic wr_reg(input logic [2:0] ad, input logic [15:0] d);
        @(negedge clk); addr = ad; wdata = d; wr = 1;
        @(negedge clk); wr = 0;
    endtask

    task automatic pulse_q(input logic [15:0] c);
        @(negedge clk); ques_cond = c;
        @(negedge clk); ques_cond = 0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk("R1 rdata", rdata, 0);
        chk("R1 qsum", {15'd0, qsum}, 0);
        chk("R1 osum", {15'd0, osum}, 0);
        rd_reg(Q_ENB, v); chk("R1 q enable", v, 0);
        rd_reg(Q_EVT, v); chk("R1 q event", v, 0);
        rd_reg(O_ENB, v); chk("R1 o enable", v, 0);
    endtask

    task automatic t_cond;
        logic [15:0] v;
        @(negedge clk); ques_cond = 16'hFFFF; oper_cond = 16'hA5A5;
        rd_reg(Q_COND, v); chk("R2 q cond", v, 16'h704B);
        rd_reg(O_COND, v); chk("R2 o cond", v, 16'hA5A5);
        rd_reg(3'd3, v);   chk("R2 reserved", v, 0);
        @(negedge clk); ques_cond = 0; oper_cond = 0;
        rd_reg(O_EVT, v);  chk("R10 o event prior", v, 16'hA5A5);
        rd_reg(Q_EVT, v);  chk("R3 q event only 13/12", v, 16'h3000);
        rd_reg(Q_EVT, v);  chk("R5 cleared by read", v, 0);
        pulse_q(16'h0003);
        rd_reg(Q_EVT, v);  chk("R3 mode bits never latch", v, 0);
    endtask

    task automatic t_sticky;
        logic [15:0] v;
        pulse_q(16'h1000);
        repeat (3) @(negedge clk);
        rd_reg(Q_COND, v); chk("R4 cond gone", v, 0);
        rd_reg(Q_ENB, v);
        rd_reg(Q_EVT, v);  chk("R4/R5 sticky then read", v, 16'h1000);
    endtask

    task automatic t_race;
        logic [15:0] v;
        pulse_q(16'h1000);
        @(negedge clk); addr = Q_EVT; rd = 1; ques_cond = 16'h2000;
        @(negedge clk); rd = 0; ques_cond = 0;
        chk("R6 read returns old", rdata, 16'h1000);
        rd_reg(Q_EVT, v); chk("R6 new event kept", v, 16'h2000);
    endtask

    task automatic t_write;
        logic [15:0] v;
        wr_reg(Q_ENB, 16'hFFFF);
        rd_reg(Q_ENB, v); chk("R7 q enable masked", v, 16'h704B);
        wr_reg(Q_EVT, 16'hFFFF);
        rd_reg(Q_EVT, v); chk("R7 event write ignored", v, 0);
        wr_reg(Q_COND, 16'hFFFF);
        rd_reg(Q_COND, v); chk("R7 cond write ignored", v, 0);
        wr_reg(O_ENB, 16'h1234);
        rd_reg(O_ENB, v); chk("R7 o enable", v, 16'h1234);
        rd_reg(Q_ENB, v); chk("R11 q enable untouched", v, 16'h704B);
    endtask

    task automatic t_summary;
        logic [15:0] v;
        wr_reg(Q_ENB, 16'h3000);
        chk("R8 no event low", {15'd0, qsum}, 0);
        @(negedge clk); ques_cond = 16'h1000;
        @(negedge clk); ques_cond = 0;
        chk("R8 rises next cycle", {15'd0, qsum}, 1);
        wr_reg(Q_ENB, 16'h2000);
        chk("R8 mask off low", {15'd0, qsum}, 0);
        rd_reg(O_EVT, v);
        rd_reg(Q_EVT, v); chk("R11 q event survives o read", v, 16'h1000);
    endtask

    task automatic t_preset;
        logic [15:0] v;
        @(negedge clk); preset = 1; wr = 1; addr = Q_ENB; wdata = 16'h0000;
        @(negedge clk); preset = 0; wr = 0;
        rd_reg(Q_ENB, v); chk("R9 q preset", v, 16'h004B);
        rd_reg(O_ENB, v); chk("R9 o preset", v, 16'h2001);
        @(negedge clk); oper_cond = 16'h8421;
        @(negedge clk); oper_cond = 0;
        chk("R8 o sum", {15'd0, osum}, 1);
        rd_reg(O_EVT, v); chk("R10 o latches all", v, 16'h8421);
        chk("R8 o sum after clear", {15'd0, osum}, 0);
    endtask

    initial begin
        fork
            begin : watchdog
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
            begin
                rst = 1; rd = 0; wr = 0; preset = 0; addr = 0; wdata = 0;
                ques_cond = 0; oper_cond = 0;
                repeat (3) @(negedge clk);
                rst = 0;
                @(negedge clk);
                t_reset;
                t_cond;
                t_sticky;
                t_race;
                t_write;
                t_summary;
                t_preset;
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule